// File: doc/BRIEF.md
# Lane Pattern-Check Status Flags

This block sits behind the pattern checker of a serial transceiver receive lane and turns the checker's per-word strobes into two status levels: `doneFlag`, meaning a pattern pass is complete, and `errFlag`, meaning a mismatch was seen. The checker raises `cycleDone` for one clock when a full pattern cycle ends. It raises `wordErr` for one clock when a received word does not match. All inputs and outputs are in the receive parallel clock domain.

There are two modes. In built-in self-test mode both flags are sticky. In pseudo-random mode the error flag is a stretched pulse: it stays up for a minimum time and then clears by itself once a later pattern cycle arrives with no mismatch.

The receive digital reset arrives asynchronously. It passes through a synchronizer and a width filter, so a glitch cannot clear the flags. The mode is taken from `modeSel` only while that filtered reset is in effect.

Top module: `lane_check_status`

## Requirements
- R1: When `rxDigRst` is high at two or more consecutive rising edges of `rxClk`, both flags read 0 after the fifth edge, counting from the first edge that saw it high. The flags stay 0 as long as the reset remains in effect.
- R2: When `rxDigRst` is high at only one rising edge, it has no effect: flags and mode keep their values.
- R3: While the reset is in effect, strobes are ignored. This covers strobes sampled at the four edges that follow the last edge seeing `rxDigRst` high. Strobes count again from the fifth such edge.
- R4: The mode is latched from `modeSel` while the reset is in effect, with 0 selecting self-test and 1 selecting pseudo-random. A change of `modeSel` at any other time has no effect until the next reset.
- R5: In self-test mode, `doneFlag` rises at the edge that samples `cycleDone` or `wordErr` high. In either mode, `doneFlag` stays high until reset.
- R6: In self-test mode, `errFlag` rises at the edge that samples `wordErr` high and stays high until reset, whatever the later strobes are.
- R7: In pseudo-random mode, only `cycleDone` sets `doneFlag`. A `wordErr` alone leaves `doneFlag` unchanged.
- R8: In pseudo-random mode, `errFlag` rises at the edge that samples `wordErr` high. It then stays high for at least three clock cycles.
- R9: In pseudo-random mode, `errFlag` clears only after a clean pass: a `cycleDone` sampled with `wordErr` low and no `wordErr` since the previous `cycleDone`. A `wordErr` sampled together with `cycleDone` belongs to the cycle that ends there. The flag falls at the later of the clean-pass edge and the third edge after the last error.
- R10: In pseudo-random mode, a new `wordErr` while `errFlag` is high restarts the three-cycle minimum and voids any clean pass seen before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rxClk | input | 1 | Receive parallel clock |
| rxDigRst | input | 1 | Asynchronous receive digital reset, active high |
| modeSel | input | 1 | Mode select: 0 self-test, 1 pseudo-random |
| cycleDone | input | 1 | One-clock strobe: a full pattern cycle was received |
| wordErr | input | 1 | One-clock strobe: a received word mismatched |
| doneFlag | output | 1 | Pattern-pass complete indicator |
| errFlag | output | 1 | Mismatch indicator |

## Verification
Strobe-driven results change at the same edge that samples the strobe. The bench therefore compares both flags one half-period after every edge. The reset takes effect four edges after its first high sample, and it releases on the fifth edge after its last one. A behavioural model in the bench keeps its own history of reset samples to reproduce both of these delays. Pseudo-random error clearing is due at the later of the clean-pass edge and the third edge after the last error. The bench compares on every cycle, so a flag that falls one cycle early or late is caught in the cycle where it happens.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic {
    MODE_BIST = 1'b0,
    MODE_PRBS = 1'b1
  } chkMode_e;

  // strobes from control to the flag datapath
  typedef struct packed {
    logic setDone;
    logic setErr;
    logic restartStretch;
    logic seqErr;
    logic seqEnd;
    logic armClear;
    logic dropErr;
  } flagCmd_t;

  // state the datapath reports back to control
  typedef struct packed {
    logic errFlag;
    logic stretchZero;
    logic seqBad;
    logic clrPend;
  } flagStat_t;

endpackage

// File: rtl/lcs_rst_qual.sv
module lcs_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 2,
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rstReqAsync,
  output logic rstInt
);

  localparam int RUN_W  = $clog2(MIN_PULSE + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [RUN_W-1:0]  RUN_SAT   = RUN_W'(MIN_PULSE - 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic [RUN_W-1:0]       runCnt;
  logic [HOLD_W-1:0]      holdCnt;
  logic                   accept;

  // synchronizer: first stage captures the asynchronous level
  always_ff @(posedge clk) syncChain[0] <= rstReqAsync;

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) syncChain[g] <= syncChain[g-1];
    end
  endgenerate

  assign syncLvl = syncChain[SYNC_STAGES-1];

  // run length of consecutive high samples, saturating
  always_ff @(posedge clk) begin
    if (!syncLvl)
      runCnt <= '0;
    else if (runCnt != RUN_SAT)
      runCnt <= runCnt + 1'b1;
  end

  assign accept = syncLvl && (runCnt >= RUN_SAT);

  // accepted reset with a minimum hold time
  always_ff @(posedge clk) begin
    if (accept) begin
      rstInt  <= 1'b1;
      holdCnt <= HOLD_LOAD;
    end else if (holdCnt != '0) begin
      rstInt  <= 1'b1;
      holdCnt <= holdCnt - 1'b1;
    end else begin
      rstInt  <= 1'b0;
      holdCnt <= '0;
    end
  end

endmodule

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
  import lcs_pkg::*;
(
  input  logic      rstInt,
  input  chkMode_e  modeLat,
  input  logic      cycleDone,
  input  logic      wordErr,
  input  flagStat_t stat,
  output flagCmd_t  cmd
);

  logic cleanPass;

  always_comb begin
    cmd       = '0;
    cleanPass = 1'b0;
    if (!rstInt) begin
      if (modeLat == MODE_BIST) begin
        cmd.setDone = cycleDone | wordErr;
        cmd.setErr  = wordErr;
      end else begin
        cleanPass          = cycleDone & ~wordErr & ~stat.seqBad;
        cmd.setDone        = cycleDone;
        cmd.setErr         = wordErr;
        cmd.restartStretch = wordErr;
        cmd.seqErr         = wordErr;
        cmd.seqEnd         = cycleDone;
        cmd.armClear       = cleanPass & stat.errFlag;
        cmd.dropErr        = stat.errFlag & stat.stretchZero &
                             (stat.clrPend | cleanPass) & ~wordErr;
      end
    end
  end

endmodule

// File: rtl/lcs_flags.sv
module lcs_flags
  import lcs_pkg::*;
#(
  parameter int ERR_STRETCH = 3
) (
  input  logic      clk,
  input  logic      rstInt,
  input  logic      modeSel,
  input  flagCmd_t  cmd,
  output chkMode_e  modeLat,
  output flagStat_t stat,
  output logic      doneFlag,
  output logic      errFlag
);

  localparam int CNT_W = $clog2(ERR_STRETCH + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERR_STRETCH - 1);

  logic [CNT_W-1:0] stretchCnt;
  logic             seqBad;
  logic             clrPend;

  always_ff @(posedge clk) begin
    if (rstInt) modeLat <= chkMode_e'(modeSel);
  end

  always_ff @(posedge clk) begin
    if (rstInt) begin
      doneFlag   <= 1'b0;
      errFlag    <= 1'b0;
      stretchCnt <= '0;
      seqBad     <= 1'b0;
      clrPend    <= 1'b0;
    end else begin
      if (cmd.setDone) doneFlag <= 1'b1;

      if (cmd.setErr)       errFlag <= 1'b1;
      else if (cmd.dropErr) errFlag <= 1'b0;

      if (cmd.restartStretch)  stretchCnt <= CNT_LOAD;
      else if (stretchCnt != '0) stretchCnt <= stretchCnt - 1'b1;

      if (cmd.seqEnd)      seqBad <= 1'b0;
      else if (cmd.seqErr) seqBad <= 1'b1;

      if (cmd.setErr || cmd.dropErr) clrPend <= 1'b0;
      else if (cmd.armClear)         clrPend <= 1'b1;
    end
  end

  assign stat.errFlag     = errFlag;
  assign stat.stretchZero = (stretchCnt == '0);
  assign stat.seqBad      = seqBad;
  assign stat.clrPend     = clrPend;

endmodule

// File: rtl/lane_check_status.sv
module lane_check_status
  import lcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 2,
  parameter int HOLD_CYCLES = 2,
  parameter int ERR_STRETCH = 3
) (
  input  logic rxClk,
  input  logic rxDigRst,
  input  logic modeSel,
  input  logic cycleDone,
  input  logic wordErr,
  output logic doneFlag,
  output logic errFlag
);

  logic      rstInt;
  chkMode_e  modeLat;
  flagCmd_t  cmd;
  flagStat_t stat;

  lcs_rst_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_PULSE  (MIN_PULSE),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_rst (
    .clk        (rxClk),
    .rstReqAsync(rxDigRst),
    .rstInt     (rstInt)
  );

  lcs_ctrl u_ctrl (
    .rstInt   (rstInt),
    .modeLat  (modeLat),
    .cycleDone(cycleDone),
    .wordErr  (wordErr),
    .stat     (stat),
    .cmd      (cmd)
  );

  lcs_flags #(
    .ERR_STRETCH(ERR_STRETCH)
  ) u_flags (
    .clk     (rxClk),
    .rstInt  (rstInt),
    .modeSel (modeSel),
    .cmd     (cmd),
    .modeLat (modeLat),
    .stat    (stat),
    .doneFlag(doneFlag),
    .errFlag (errFlag)
  );

endmodule

// File: rtl/lcs_checker.sv
module lcs_checker (
  input logic clk,
  input logic rstInt,
  input logic rxDigRst,
  input logic modeLat,
  input logic cycleDone,
  input logic wordErr,
  input logic doneFlag,
  input logic errFlag
);

  // R1: an accepted reset clears both flags at the next edge
  p_rst_clear_r1: assert property (@(posedge clk)
    rstInt |=> (!doneFlag && !errFlag));

  // R2: internal reset only starts after two consecutive high samples
  // (the delays match the default two-stage synchronizer)
  p_rst_qual_r2: assert property (@(posedge clk)
    $rose(rstInt) |-> ($past(rxDigRst, 3) && $past(rxDigRst, 4)));

  // R5: done is sticky outside reset
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rstInt)
    doneFlag |=> doneFlag);

  // R6: self-test error is sticky
  p_bist_err_sticky_r6: assert property (@(posedge clk) disable iff (rstInt)
    (!modeLat && errFlag) |=> errFlag);

  // R7: in pseudo-random mode only cycleDone raises done
  p_done_src_r7: assert property (@(posedge clk) disable iff (rstInt)
    $rose(doneFlag) |-> ($past(cycleDone) || (!modeLat && $past(wordErr))));

  // R8: an error strobe raises the flag
  p_err_set_r8: assert property (@(posedge clk) disable iff (rstInt)
    (!rstInt && wordErr) |=> errFlag);

  // R8: error flag lasts at least three cycles
  p_err_min_r8: assert property (@(posedge clk) disable iff (rstInt)
    $rose(errFlag) |=> errFlag ##1 errFlag);

endmodule

bind lane_check_status lcs_checker u_chk (
  .clk      (rxClk),
  .rstInt   (rstInt),
  .rxDigRst (rxDigRst),
  .modeLat  (modeLat),
  .cycleDone(cycleDone),
  .wordErr  (wordErr),
  .doneFlag (doneFlag),
  .errFlag  (errFlag)
);

// File: tb/sim_lane_check_status.sv
`timescale 1ns/1ps
module sim_lane_check_status;

  logic rxClk = 1'b0;
  logic rxDigRst = 1'b1;
  logic modeSel = 1'b0;
  logic cycleDone = 1'b0;
  logic wordErr = 1'b0;
  logic doneFlag, errFlag;

  int    testsRun = 0;
  int    testsFail = 0;
  bit    checkEn = 1'b0;
  bit    finished = 1'b0;
  string curReq = "R1";

  always #4 rxClk = ~rxClk;

  lane_check_status u0 (
    .rxClk    (rxClk),
    .rxDigRst (rxDigRst),
    .modeSel  (modeSel),
    .cycleDone(cycleDone),
    .wordErr  (wordErr),
    .doneFlag (doneFlag),
    .errFlag  (errFlag)
  );

  // ---------------- behavioural reference ----------------
  bit rstHist[$] = '{0, 0, 0, 0};  // index 0 = most recent sample
  bit rstActM = 0;
  bit modeM = 0;
  bit doneM = 0, errM = 0;
  bit seqDirty = 0, clearArmed = 0;
  int errAge = 1000;

  always @(posedge rxClk) begin
    bit cleanNow;
    if (rstActM) begin
      modeM = modeSel; doneM = 0; errM = 0;
      seqDirty = 0; clearArmed = 0; errAge = 1000;
    end else if (!modeM) begin
      if (cycleDone || wordErr) doneM = 1;
      if (wordErr) errM = 1;
    end else begin
      if (cycleDone) doneM = 1;
      cleanNow = cycleDone && !wordErr && !seqDirty;
      if (wordErr) begin
        errM = 1; errAge = 0; clearArmed = 0;
        seqDirty = !cycleDone;
      end else begin
        if (errAge < 1000) errAge++;
        if (cycleDone) seqDirty = 0;
        if (cleanNow && errM) clearArmed = 1;
        if (errM && clearArmed && errAge >= 3) begin
          errM = 0; clearArmed = 0;
        end
      end
    end
    // accepted: two consecutive high samples, two and three edges back
    rstActM = (rstHist[1] && rstHist[2]) || (rstHist[2] && rstHist[3]);
    rstHist.push_front(rxDigRst);
    void'(rstHist.pop_back());
  end

  task automatic chk(string req, string what, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge rxClk) begin
    if (checkEn && !finished) begin
      chk(curReq, "doneFlag", doneFlag, doneM);
      chk(curReq, "errFlag", errFlag, errM);
    end
  end

  task automatic tick(input logic cd, input logic we);
    cycleDone = cd;
    wordErr = we;
    @(negedge rxClk);
    cycleDone = 1'b0;
    wordErr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic rstPulse(int n, logic m);
    modeSel = m;
    rxDigRst = 1'b1;
    idle(n);
    rxDigRst = 1'b0;
    idle(6);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge rxClk);
    idle(8);
    rxDigRst = 1'b0;
    idle(6);
    // R1 reset state
    chk("R1", "reset doneFlag", doneFlag, 1'b0);
    chk("R1", "reset errFlag", errFlag, 1'b0);
    checkEn = 1'b1;

    curReq = "R5"; tick(1, 0); idle(3);
    curReq = "R1"; rstPulse(3, 0);
    curReq = "R6"; tick(0, 1); idle(2); tick(1, 0); tick(1, 0); idle(4);
    chk("R6", "sticky errFlag", errFlag, 1'b1);
    chk("R5", "done after error", doneFlag, 1'b1);

    curReq = "R2"; rstPulse(1, 1);
    chk("R2", "glitch errFlag", errFlag, 1'b1);
    chk("R2", "glitch doneFlag", doneFlag, 1'b1);
    curReq = "R2"; tick(0, 0); tick(1, 1); idle(2);  // still self-test mode

    curReq = "R1"; rstPulse(2, 0);
    chk("R1", "min pulse doneFlag", doneFlag, 1'b0);

    // R3 strobes during reset and its tail
    curReq = "R3";
    rxDigRst = 1'b1;
    tick(1, 1); tick(1, 1); tick(1, 1);
    rxDigRst = 1'b0;
    tick(0, 1); tick(0, 1); tick(0, 1); tick(0, 1);
    chk("R3", "tail errFlag", errFlag, 1'b0);
    tick(0, 1);
    chk("R3", "after tail errFlag", errFlag, 1'b1);
    idle(2);

    // pseudo-random mode; later modeSel change must be ignored
    curReq = "R4"; rstPulse(3, 1);
    modeSel = 1'b0;
    curReq = "R7"; tick(0, 1);
    chk("R7", "done on error only", doneFlag, 1'b0);
    idle(4);
    curReq = "R8"; tick(1, 0); tick(1, 0); idle(2);   // clears R9
    chk("R9", "cleared after clean pass", errFlag, 1'b0);
    chk("R7", "done after cycle", doneFlag, 1'b1);
    curReq = "R8"; tick(0, 1); tick(1, 0); tick(1, 0); tick(0, 0); idle(2);
    curReq = "R9"; tick(0, 1); idle(5); tick(1, 0); idle(5);
    chk("R9", "held until clean pass", errFlag, 1'b1);
    tick(1, 0); idle(2);
    curReq = "R9"; tick(1, 1); tick(1, 0); idle(3);
    curReq = "R10"; tick(0, 1); tick(1, 0); tick(0, 1); tick(1, 0); tick(1, 0); idle(5);
    curReq = "R10"; tick(0, 1); idle(1); tick(1, 0); tick(1, 0); tick(0, 1); idle(6);
    chk("R10", "error after clean pass", errFlag, 1'b1);
    tick(1, 0); tick(1, 0); idle(3);
    curReq = "R4"; chk("R4", "mode still pseudo-random", errFlag, 1'b0);

    // back to self-test through reset
    curReq = "R4"; rstPulse(2, 0);
    curReq = "R6"; tick(0, 1); tick(1, 0); tick(1, 0); idle(5);
    chk("R6", "self-test no auto clear", errFlag, 1'b1);

    idle(2);
    finish_run();
  end

endmodule